// File: doc/BRIEF.md
# Dual-Direction Doorbell Interrupt Unit

This block lets a local processor and an agent on the PCI side raise interrupts toward each other through two doorbell registers. Writing ones into a doorbell latches request bits; while any latched bit is unmasked, the interrupt line toward the servicing side is high. The servicing side acknowledges a request by writing ones to the bits it has handled. The unit has an outbound doorbell, which the processor rings toward PCI, and an inbound doorbell, which the PCI side rings toward the processor. Each doorbell has its own mask register.

Both sides reach the same five-word register window through identical synchronous ports. Each port has an address, write data, a write strobe, a read strobe and read data. A mask bit only gates the interrupt output; the doorbell bit is still latched. The outbound doorbell can be rung from either side through a set-only alias, so requests can travel either way. When both ports touch the same doorbell in the same cycle, their effects are merged bit by bit.

Top module: `doorbell_unit`

## Requirements
- R1: After reset both doorbells read 0, both masks read 32'hFFFF_FFFF and both interrupt lines are low.
- R2: A processor write to the outbound doorbell (offset 0x1C2C) sets each bit written as 1; bits written as 0 keep their value.
- R3: A PCI write to the outbound doorbell (0x1C2C) clears each bit written as 1. A write from either port to the outbound set alias (0x1C28) sets each bit written as 1.
- R4: A PCI write to the inbound doorbell (0x1C20) sets each bit written as 1; a processor write there clears each bit written as 1.
- R5: A masked doorbell bit is still latched and reads back as 1.
- R6: irq_cpu equals the OR over all bits of (inbound doorbell AND NOT inbound mask), and irq_pci the same for the outbound pair. Each line is registered, so it changes one clock after the register state that causes the change.
- R7: If a set and a clear reach the same doorbell bit in the same cycle, the bit ends up set.
- R8: Sets arriving from both ports in the same cycle are all latched.
- R9: Only the processor port writes the inbound mask (0x1C24), and only the PCI port writes the outbound mask (0x1C30). A write to a mask from the other port has no effect. Both ports can read both masks.
- R10: When re is high, read data is the addressed register in the same cycle, and the alias 0x1C28 returns the outbound doorbell. It is 0 when re is low or the address is not one of the five offsets.
- R11: A write to an address outside the five offsets changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_addr | input | 16 | Processor port byte address |
| cpu_wdata | input | 32 | Processor port write data |
| cpu_we | input | 1 | Processor port write strobe |
| cpu_re | input | 1 | Processor port read strobe |
| cpu_rdata | output | 32 | Processor port read data |
| pci_addr | input | 16 | PCI port byte address |
| pci_wdata | input | 32 | PCI port write data |
| pci_we | input | 1 | PCI port write strobe |
| pci_re | input | 1 | PCI port read strobe |
| pci_rdata | output | 32 | PCI port read data |
| irq_cpu | output | 1 | Level interrupt toward the processor |
| irq_pci | output | 1 | Level interrupt toward the PCI side |

## Verification
The assertions assume that strobes and addresses are stable around each rising edge and that reset is held for at least one edge. With that, the previous-cycle state they compare against is always a post-reset value. The latching checks also assume that a write on a doorbell address is a full-word write that may overlap a clear from the other port. The stimulus meets these assumptions by changing every input only on the falling edge. Every write lasts exactly one cycle, and the sweeps release reset before the first access.

// File: rtl/dbu_pkg.sv
package dbu_pkg;

    // Register selected by one port's address.
    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_IN_DB,
        SEL_IN_MASK,
        SEL_OUT_SET,
        SEL_OUT_DB,
        SEL_OUT_MASK
    } dbu_sel_e;

endpackage

// File: rtl/dbu_addr_dec.sv
module dbu_addr_dec
    import dbu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] IN_DB_OFS    = 16'h1C20,
    parameter logic [ADDR_W-1:0] IN_MASK_OFS  = 16'h1C24,
    parameter logic [ADDR_W-1:0] OUT_SET_OFS  = 16'h1C28,
    parameter logic [ADDR_W-1:0] OUT_DB_OFS   = 16'h1C2C,
    parameter logic [ADDR_W-1:0] OUT_MASK_OFS = 16'h1C30
) (
    input  logic [ADDR_W-1:0] addr,
    output dbu_sel_e          sel
);

    always_comb begin
        if (addr == IN_DB_OFS)         sel = SEL_IN_DB;
        else if (addr == IN_MASK_OFS)  sel = SEL_IN_MASK;
        else if (addr == OUT_SET_OFS)  sel = SEL_OUT_SET;
        else if (addr == OUT_DB_OFS)   sel = SEL_OUT_DB;
        else if (addr == OUT_MASK_OFS) sel = SEL_OUT_MASK;
        else                           sel = SEL_NONE;
    end

endmodule

// File: rtl/dbu_bank.sv
module dbu_bank #(
    parameter int DB_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DB_W-1:0] set_bits,
    input  logic [DB_W-1:0] clr_bits,
    input  logic            mask_we,
    input  logic [DB_W-1:0] mask_wdata,
    output logic [DB_W-1:0] db,
    output logic [DB_W-1:0] mask,
    output logic            irq
);

    typedef struct packed {
        logic [DB_W-1:0] db;
        logic [DB_W-1:0] mask;
        logic            irq;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        // A set overrides a clear on the same bit.
        st_d.db   = (st_q.db & ~clr_bits) | set_bits;
        if (mask_we) begin
            st_d.mask = mask_wdata;
        end
        st_d.irq  = |(st_q.db & ~st_q.mask);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{db: '0, mask: '1, irq: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign db   = st_q.db;
    assign mask = st_q.mask;
    assign irq  = st_q.irq;

endmodule

// File: rtl/doorbell_unit.sv
module doorbell_unit
    import dbu_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DB_W   = 32,
    parameter logic [ADDR_W-1:0] IN_DB_OFS    = 16'h1C20,
    parameter logic [ADDR_W-1:0] IN_MASK_OFS  = 16'h1C24,
    parameter logic [ADDR_W-1:0] OUT_SET_OFS  = 16'h1C28,
    parameter logic [ADDR_W-1:0] OUT_DB_OFS   = 16'h1C2C,
    parameter logic [ADDR_W-1:0] OUT_MASK_OFS = 16'h1C30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DB_W-1:0]   cpu_wdata,
    input  logic              cpu_we,
    input  logic              cpu_re,
    output logic [DB_W-1:0]   cpu_rdata,
    input  logic [ADDR_W-1:0] pci_addr,
    input  logic [DB_W-1:0]   pci_wdata,
    input  logic              pci_we,
    input  logic              pci_re,
    output logic [DB_W-1:0]   pci_rdata,
    output logic              irq_cpu,
    output logic              irq_pci
);

    localparam logic [DB_W-1:0] NONE_BITS = '0;

    dbu_sel_e cpu_sel, pci_sel;

    logic [DB_W-1:0] in_set, in_clr, out_set, out_clr;
    logic            in_mask_we, out_mask_we;
    logic [DB_W-1:0] in_db_q, in_mask_q, out_db_q, out_mask_q;

    dbu_addr_dec #(
        .ADDR_W(ADDR_W), .IN_DB_OFS(IN_DB_OFS), .IN_MASK_OFS(IN_MASK_OFS),
        .OUT_SET_OFS(OUT_SET_OFS), .OUT_DB_OFS(OUT_DB_OFS), .OUT_MASK_OFS(OUT_MASK_OFS)
    ) u_cpu_dec (
        .addr (cpu_addr),
        .sel  (cpu_sel)
    );

    dbu_addr_dec #(
        .ADDR_W(ADDR_W), .IN_DB_OFS(IN_DB_OFS), .IN_MASK_OFS(IN_MASK_OFS),
        .OUT_SET_OFS(OUT_SET_OFS), .OUT_DB_OFS(OUT_DB_OFS), .OUT_MASK_OFS(OUT_MASK_OFS)
    ) u_pci_dec (
        .addr (pci_addr),
        .sel  (pci_sel)
    );

    // Write routing: ringing side sets, servicing side clears; masks per owner.
    always_comb begin
        out_set = NONE_BITS;
        out_clr = NONE_BITS;
        in_set  = NONE_BITS;
        in_clr  = NONE_BITS;
        if (cpu_we && (cpu_sel == SEL_OUT_DB || cpu_sel == SEL_OUT_SET)) out_set = out_set | cpu_wdata;
        if (pci_we && (pci_sel == SEL_OUT_SET))                          out_set = out_set | pci_wdata;
        if (pci_we && (pci_sel == SEL_OUT_DB))                           out_clr = pci_wdata;
        if (pci_we && (pci_sel == SEL_IN_DB))                            in_set  = pci_wdata;
        if (cpu_we && (cpu_sel == SEL_IN_DB))                            in_clr  = cpu_wdata;
        in_mask_we  = cpu_we && (cpu_sel == SEL_IN_MASK);
        out_mask_we = pci_we && (pci_sel == SEL_OUT_MASK);
    end

    dbu_bank #(.DB_W(DB_W)) u_in_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits   (in_set),
        .clr_bits   (in_clr),
        .mask_we    (in_mask_we),
        .mask_wdata (cpu_wdata),
        .db         (in_db_q),
        .mask       (in_mask_q),
        .irq        (irq_cpu)
    );

    dbu_bank #(.DB_W(DB_W)) u_out_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_bits   (out_set),
        .clr_bits   (out_clr),
        .mask_we    (out_mask_we),
        .mask_wdata (pci_wdata),
        .db         (out_db_q),
        .mask       (out_mask_q),
        .irq        (irq_pci)
    );

    function automatic logic [DB_W-1:0] read_mux(
        input dbu_sel_e        sel,
        input logic            re,
        input logic [DB_W-1:0] idb,
        input logic [DB_W-1:0] imask,
        input logic [DB_W-1:0] odb,
        input logic [DB_W-1:0] omask
    );
        logic [DB_W-1:0] v;
        v = NONE_BITS;
        if (re) begin
            case (sel)
                SEL_IN_DB:    v = idb;
                SEL_IN_MASK:  v = imask;
                SEL_OUT_SET:  v = odb;
                SEL_OUT_DB:   v = odb;
                SEL_OUT_MASK: v = omask;
                default:      v = NONE_BITS;
            endcase
        end
        return v;
    endfunction

    always_comb begin
        cpu_rdata = read_mux(cpu_sel, cpu_re, in_db_q, in_mask_q, out_db_q, out_mask_q);
        pci_rdata = read_mux(pci_sel, pci_re, in_db_q, in_mask_q, out_db_q, out_mask_q);
    end

endmodule

// File: rtl/dbu_chk.sv
module dbu_chk #(
    parameter int ADDR_W = 16,
    parameter int DB_W   = 32,
    parameter logic [ADDR_W-1:0] IN_DB_OFS    = 16'h1C20,
    parameter logic [ADDR_W-1:0] IN_MASK_OFS  = 16'h1C24,
    parameter logic [ADDR_W-1:0] OUT_DB_OFS   = 16'h1C2C,
    parameter logic [ADDR_W-1:0] OUT_MASK_OFS = 16'h1C30
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] cpu_addr,
    input logic [DB_W-1:0]   cpu_wdata,
    input logic              cpu_we,
    input logic              cpu_re,
    input logic [DB_W-1:0]   cpu_rdata,
    input logic [ADDR_W-1:0] pci_addr,
    input logic [DB_W-1:0]   pci_wdata,
    input logic              pci_we,
    input logic              irq_cpu,
    input logic              irq_pci,
    input logic [DB_W-1:0]   in_db,
    input logic [DB_W-1:0]   in_mask,
    input logic [DB_W-1:0]   out_db,
    input logic [DB_W-1:0]   out_mask
);

    AST_IRQ_CPU_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_cpu == $past(|(in_db & ~in_mask))); // R6

    AST_IRQ_PCI_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pci == $past(|(out_db & ~out_mask))); // R6

    AST_IN_SET_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (pci_we && pci_addr == IN_DB_OFS) |=> ((in_db & $past(pci_wdata)) == $past(pci_wdata))); // R4

    AST_OUT_SET_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_we && cpu_addr == OUT_DB_OFS) |=> ((out_db & $past(cpu_wdata)) == $past(cpu_wdata))); // R2

    AST_IN_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(cpu_we && cpu_addr == IN_MASK_OFS) |=> $stable(in_mask)); // R9

    AST_OUT_MASK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(pci_we && pci_addr == OUT_MASK_OFS) |=> $stable(out_mask)); // R9

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_re |-> (cpu_rdata == '0)); // R10

endmodule

bind doorbell_unit dbu_chk #(
    .ADDR_W(ADDR_W), .DB_W(DB_W), .IN_DB_OFS(IN_DB_OFS), .IN_MASK_OFS(IN_MASK_OFS),
    .OUT_DB_OFS(OUT_DB_OFS), .OUT_MASK_OFS(OUT_MASK_OFS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .cpu_we    (cpu_we),
    .cpu_re    (cpu_re),
    .cpu_rdata (cpu_rdata),
    .pci_addr  (pci_addr),
    .pci_wdata (pci_wdata),
    .pci_we    (pci_we),
    .irq_cpu   (irq_cpu),
    .irq_pci   (irq_pci),
    .in_db     (in_db_q),
    .in_mask   (in_mask_q),
    .out_db    (out_db_q),
    .out_mask  (out_mask_q)
);

// File: tb/tb_doorbell_unit.sv
module tb_doorbell_unit;

    localparam logic [15:0] A_IN_DB    = 16'h1C20;
    localparam logic [15:0] A_IN_MASK  = 16'h1C24;
    localparam logic [15:0] A_OUT_SET  = 16'h1C28;
    localparam logic [15:0] A_OUT_DB   = 16'h1C2C;
    localparam logic [15:0] A_OUT_MASK = 16'h1C30;
    localparam logic [15:0] A_HOLE     = 16'h1C40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cpu_addr = '0, pci_addr = '0;
    logic [31:0] cpu_wdata = '0, pci_wdata = '0;
    logic        cpu_we = 1'b0, cpu_re = 1'b0, pci_we = 1'b0, pci_re = 1'b0;
    logic [31:0] cpu_rdata, pci_rdata;
    logic        irq_cpu, irq_pci;

    always #5 clk = ~clk;

    doorbell_unit dut (
        .clk(clk), .rst_n(rst_n),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_we(cpu_we), .cpu_re(cpu_re), .cpu_rdata(cpu_rdata),
        .pci_addr(pci_addr), .pci_wdata(pci_wdata), .pci_we(pci_we), .pci_re(pci_re), .pci_rdata(pci_rdata),
        .irq_cpu(irq_cpu), .irq_pci(irq_pci)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    // Bench model of the four registers.
    logic [31:0] m_in = '0, m_imask = '1, m_out = '0, m_omask = '1;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step(input logic [15:0] ca, input logic [31:0] cw, input bit cwe,
                        input logic [15:0] pa, input logic [31:0] pw, input bit pwe);
        logic [31:0] o_set, o_clr, i_set, i_clr;
        @(negedge clk);
        cpu_addr = ca; cpu_wdata = cw; cpu_we = cwe; cpu_re = 1'b0;
        pci_addr = pa; pci_wdata = pw; pci_we = pwe; pci_re = 1'b0;
        @(posedge clk);
        o_set = '0; o_clr = '0; i_set = '0; i_clr = '0;
        if (cwe && (ca == A_OUT_DB || ca == A_OUT_SET)) o_set = o_set | cw;
        if (pwe && pa == A_OUT_SET) o_set = o_set | pw;
        if (pwe && pa == A_OUT_DB)  o_clr = pw;
        if (pwe && pa == A_IN_DB)   i_set = pw;
        if (cwe && ca == A_IN_DB)   i_clr = cw;
        if (cwe && ca == A_IN_MASK)  m_imask = cw;
        if (pwe && pa == A_OUT_MASK) m_omask = pw;
        m_out = (m_out & ~o_clr) | o_set;
        m_in  = (m_in & ~i_clr) | i_set;
        #1;
        cpu_we = 1'b0; pci_we = 1'b0;
    endtask

    task automatic cw_(input logic [15:0] a, input logic [31:0] d);
        step(a, d, 1'b1, 16'h0, 32'h0, 1'b0);
    endtask

    task automatic pw_(input logic [15:0] a, input logic [31:0] d);
        step(16'h0, 32'h0, 1'b0, a, d, 1'b1);
    endtask

    task automatic idle();
        step(16'h0, 32'h0, 1'b0, 16'h0, 32'h0, 1'b0);
    endtask

    task automatic rd_both(input logic [15:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cpu_addr = a; pci_addr = a; cpu_re = 1'b1; pci_re = 1'b1;
        #1;
        chk({tag, " cpu read"}, cpu_rdata, exp);
        chk({tag, " pci read"}, pci_rdata, exp);
        cpu_re = 1'b0; pci_re = 1'b0;
    endtask

    task automatic chk_all(input string tag);
        rd_both(A_IN_DB,    m_in,    tag);
        rd_both(A_IN_MASK,  m_imask, tag);
        rd_both(A_OUT_DB,   m_out,   tag);
        rd_both(A_OUT_SET,  m_out,   tag);
        rd_both(A_OUT_MASK, m_omask, tag);
    endtask

    task automatic chk_irqs(input string tag);
        chk({tag, " irq_cpu"}, {31'b0, irq_cpu}, {31'b0, |(m_in & ~m_imask)});
        chk({tag, " irq_pci"}, {31'b0, irq_pci}, {31'b0, |(m_out & ~m_omask)});
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_all("R1 reset");
        chk_irqs("R1 reset");

        // R2 processor rings outbound bit by bit; R5 masked bits still latch
        for (int i = 0; i < 32; i++) begin
            cw_(A_OUT_DB, 32'd1 << i);
            rd_both(A_OUT_DB, m_out, "R2 out set");
        end
        idle();
        chk("R5 out latched under mask", m_out, 32'hFFFF_FFFF);
        chk_irqs("R5 masked out");
        cw_(A_OUT_DB, 32'h0);
        rd_both(A_OUT_DB, m_out, "R2 zero write");

        // R3 PCI acknowledges bit by bit, then sets through the alias
        for (int i = 0; i < 32; i++) begin
            pw_(A_OUT_DB, 32'd1 << i);
            rd_both(A_OUT_DB, m_out, "R3 out clear");
        end
        pw_(A_OUT_SET, 32'hA5A5_0F0F);
        rd_both(A_OUT_DB, m_out, "R3 pci alias set");
        cw_(A_OUT_SET, 32'h0000_F000);
        rd_both(A_OUT_DB, m_out, "R3 cpu alias set");
        pw_(A_OUT_DB, 32'hFFFF_FFFF);
        rd_both(A_OUT_DB, m_out, "R3 clear all");

        // R4 inbound: PCI sets, processor clears
        for (int i = 0; i < 32; i++) begin
            pw_(A_IN_DB, 32'd1 << i);
            rd_both(A_IN_DB, m_in, "R4 in set");
        end
        idle();
        chk_irqs("R5 masked in");
        for (int i = 0; i < 32; i++) begin
            cw_(A_IN_DB, 32'd1 << i);
            rd_both(A_IN_DB, m_in, "R4 in clear");
        end

        // R9 mask ownership
        cw_(A_OUT_MASK, 32'h0);
        pw_(A_IN_MASK, 32'h0);
        chk_all("R9 foreign mask write ignored");
        cw_(A_IN_MASK, 32'h1234_5678);
        pw_(A_OUT_MASK, 32'h8765_4321);
        chk_all("R9 owner mask write");

        // R6 sweep of doorbell bit against unmasked bit, both directions
        for (int i = 0; i < 32; i++) begin
            for (int j = 0; j < 32; j++) begin
                step(A_OUT_DB, 32'd1 << i, 1'b1, A_IN_DB, 32'd1 << i, 1'b1);
                step(A_IN_MASK, ~(32'd1 << j), 1'b1, A_OUT_MASK, ~(32'd1 << j), 1'b1);
                idle();
                idle();
                chk_irqs("R6 sweep");
                step(A_IN_DB, 32'hFFFF_FFFF, 1'b1, A_OUT_DB, 32'hFFFF_FFFF, 1'b1);
            end
        end

        // R6 one-clock latency of the interrupt
        step(A_IN_MASK, 32'h0, 1'b1, A_OUT_MASK, 32'h0, 1'b1);
        idle();
        idle();
        chk_irqs("R6 idle low");
        pw_(A_IN_DB, 32'h0000_0008);
        chk("R6 irq_cpu not yet", {31'b0, irq_cpu}, 32'h0);
        @(posedge clk); #1;
        chk("R6 irq_cpu one clock later", {31'b0, irq_cpu}, 32'h1);
        cw_(A_IN_DB, 32'h0000_0008);
        chk("R6 irq_cpu still high", {31'b0, irq_cpu}, 32'h1);
        @(posedge clk); #1;
        chk("R6 irq_cpu dropped", {31'b0, irq_cpu}, 32'h0);
        cw_(A_OUT_SET, 32'h8000_0000);
        chk("R6 irq_pci not yet", {31'b0, irq_pci}, 32'h0);
        @(posedge clk); #1;
        chk("R6 irq_pci one clock later", {31'b0, irq_pci}, 32'h1);
        pw_(A_OUT_DB, 32'hFFFF_FFFF);

        // R7 set beats clear on the same bit
        cw_(A_OUT_DB, 32'hFF00_FF00);
        step(A_OUT_DB, 32'h0F0F_0F0F, 1'b1, A_OUT_DB, 32'hFFFF_0000, 1'b1);
        rd_both(A_OUT_DB, m_out, "R7 out set over clear");
        chk("R7 out value", m_out, 32'h0F0F_FF0F);
        pw_(A_IN_DB, 32'h00FF_00FF);
        step(A_IN_DB, 32'hFFFF_FFFF, 1'b1, A_IN_DB, 32'h0000_0F0F, 1'b1);
        rd_both(A_IN_DB, 32'h0000_0F0F, "R7 in set over clear");

        // R8 simultaneous sets from both ports merged
        pw_(A_OUT_DB, 32'hFFFF_FFFF);
        step(A_OUT_DB, 32'h1111_0000, 1'b1, A_OUT_SET, 32'h0000_2222, 1'b1);
        rd_both(A_OUT_DB, 32'h1111_2222, "R8 merged sets");
        step(A_OUT_SET, 32'h4000_0000, 1'b1, A_OUT_SET, 32'h0000_0004, 1'b1);
        rd_both(A_OUT_DB, 32'h5111_2226, "R8 merged alias sets");

        // R10 read gating and unmapped reads
        rd_both(A_HOLE, 32'h0, "R10 unmapped read");
        @(negedge clk);
        cpu_addr = A_OUT_DB; pci_addr = A_OUT_DB; cpu_re = 1'b0; pci_re = 1'b0;
        #1;
        chk("R10 cpu no re", cpu_rdata, 32'h0);
        chk("R10 pci no re", pci_rdata, 32'h0);

        // R11 writes to a hole change nothing
        step(A_HOLE, 32'hFFFF_FFFF, 1'b1, A_HOLE, 32'hFFFF_FFFF, 1'b1);
        step(A_HOLE - 16'h4, 32'h0, 1'b1, A_HOLE + 16'h4, 32'h0, 1'b1);
        chk_all("R11 unmapped write");
        idle();
        chk_irqs("R11 irqs");

        summary();
    end

endmodule